// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block guards a processor against hangs. A down counter is loaded from a programmable value and counts one step per clock once the interrupt enable is set. The first time it reaches zero it sets an interrupt status flag, drives the interrupt line and starts the count again from the load value. Software is expected to service that interrupt by writing the clear register, which restarts the count and cancels the escalation.

If the flag is still set when the counter next reaches zero and the reset enable is set, the block emits a one-cycle reset request and the counter halts at zero until software re-arms it. Without reset enable, a second expiry only reloads the counter. A key-guarded lock blocks writes to the load, control and clear registers, so that runaway code cannot silence the watchdog by accident. Both enables, once set, can only be cleared by system reset.

Top module: `wdt_guard`

## Requirements
- R1: After reset, LOAD and COUNT read 0xFFFFFFFF, CTRL, STATUS and LOCK read 0, and `wdt_irq` and `wdt_rst_pulse` are low.
- R2: Word addresses are 0 LOAD (read/write), 1 COUNT (read only), 2 CTRL (bit 0 interrupt enable, bit 1 reset enable), 3 CLEAR (write only, reads 0), 4 STATUS (bit 0 expiry flag), 5 LOCK. The counter falls by one per clock only while the interrupt enable is set, and holds its value otherwise.
- R3: An accepted write to LOAD puts the written value into the counter on the same edge and re-arms a halted counter.
- R4: When the counter is 0 with the flag clear, the next edge sets the flag and reloads the counter, so the flag rises L+1 edges after a load or clear with load value L. `wdt_irq` is high while the flag and the interrupt enable are both set.
- R5: When the counter is 0 with the flag set and reset enable on, the next edge gives a `wdt_rst_pulse` exactly one cycle wide, and the counter then stays at 0 until LOAD or CLEAR is written.
- R6: With reset enable off, a second expiry gives no reset pulse, reloads the counter and leaves the flag set.
- R7: An accepted write to CLEAR drops the flag and `wdt_irq` and reloads the counter, so a pending escalation is cancelled.
- R8: Writing 0 to a CTRL bit that is already set leaves it set; only system reset clears the enables.
- R9: Writing 0x1ACCE551 to LOCK unlocks the block; writing any other value locks it. LOCK reads 1 when locked and 0 when unlocked.
- R10: While locked, writes to LOAD, CTRL and CLEAR change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdt_irq | output | 1 | Interrupt after the first expiry, meant for a non-maskable input |
| wdt_rst_pulse | output | 1 | One-cycle system reset request after the second expiry |

## Verification
On every cycle the assertions check the following. The reset pulse is one cycle wide and comes only from a zero count with the flag and reset enable already set. The flag rises only from a zero count. The enables never fall. The counter holds while disabled or halted. A locked load write leaves the load value alone, and an accepted clear drops the flag. The exact expiry cycles for a given load value, the escalation path, the cancellation by clear, and the effect of the lock key and of non-key values can only be shown by the bench. It does this through scheduled expiry and reset events and register read-backs.

// File: rtl/wdt_guard_pkg.sv
// Shared constants and types of the two-stage watchdog.
// Assumes a 32-bit register bus with word addresses.
package wdt_guard_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD   = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_STATUS = 3'd4,
        REG_LOCK   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic ctrl;
        logic clear;
        logic lock;
    } wr_strobe_t;
endpackage

// File: rtl/wdt_guard_decode.sv
// Turns a bus write into per-register strobes. Writes to LOAD, CTRL and
// CLEAR are dropped while locked; LOCK writes always pass.
// Assumes reg_addr is valid in the cycle reg_we is high.
module wdt_guard_decode
    import wdt_guard_pkg::*;
(
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              locked,
    output wr_strobe_t        strobe
);
    // Address decode gated by the lock state
    always_comb begin
        strobe       = '0;
        strobe.lock  = reg_we && (reg_sel_e'(reg_addr) == REG_LOCK);
        strobe.load  = reg_we && !locked && (reg_sel_e'(reg_addr) == REG_LOAD);
        strobe.ctrl  = reg_we && !locked && (reg_sel_e'(reg_addr) == REG_CTRL);
        strobe.clear = reg_we && !locked && (reg_sel_e'(reg_addr) == REG_CLEAR);
    end
endmodule

// File: rtl/wdt_guard_lock.sv
// Key-based lock: the key value unlocks, any other written value locks.
// Assumes the block leaves reset unlocked.
module wdt_guard_lock
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    // Lock flag update on every LOCK write
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (lock_wr)
            locked <= (wdata != UNLOCK_KEY);
    end
endmodule

// File: rtl/wdt_guard_cfg.sv
// Holds the load value and the two sticky enables.
// Assumes strobes are already gated by the lock.
module wdt_guard_cfg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] load_in,
    input  logic [1:0]       ctrl_in,
    output logic [CNT_W-1:0] load_val,
    output logic             en_irq,
    output logic             en_rst
);
    // Load register: written value kept until the next accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_val <= '1;
        else if (load_wr)
            load_val <= load_in;
    end

    // Enables can be set by software but only cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_irq <= 1'b0;
            en_rst <= 1'b0;
        end else if (ctrl_wr) begin
            en_irq <= en_irq | ctrl_in[0];
            en_rst <= en_rst | ctrl_in[1];
        end
    end
endmodule

// File: rtl/wdt_guard_count.sv
// Down counter with two-stage escalation. First zero sets the flag and
// reloads; second zero with the flag still set either pulses reset and
// halts (reset enabled) or reloads (reset disabled).
// Assumes load_wr and clear_wr are never high together.
module wdt_guard_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_irq,
    input  logic             en_rst,
    input  logic             load_wr,
    input  logic             clear_wr,
    input  logic [CNT_W-1:0] load_in,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_val,
    output logic             st_flag,
    output logic             halted,
    output logic             rst_pulse
);
    logic at_zero;
    logic running;

    // Expiry and run conditions
    always_comb begin
        at_zero = (count_val == '0);
        running = en_irq && !halted;
    end

    // Counter, flag, halt and reset pulse sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_val <= '1;
            st_flag   <= 1'b0;
            halted    <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (load_wr) begin
                count_val <= load_in;
                halted    <= 1'b0;
            end else if (clear_wr) begin
                count_val <= load_val;
                st_flag   <= 1'b0;
                halted    <= 1'b0;
            end else if (running) begin
                if (!at_zero) begin
                    count_val <= count_val - 1'b1;
                end else if (!st_flag) begin
                    st_flag   <= 1'b1;
                    count_val <= load_val;
                end else if (en_rst) begin
                    rst_pulse <= 1'b1;
                    halted    <= 1'b1;
                end else begin
                    count_val <= load_val;
                end
            end
        end
    end
endmodule

// File: rtl/wdt_guard.sv
// Two-stage lockable watchdog top: register decode, lock, configuration,
// counter and read mux. Assumes CNT_W <= 32.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst_pulse
);
    wr_strobe_t       strobe;
    logic             locked;
    logic             en_irq;
    logic             en_rst;
    logic             st_flag;
    logic             halted;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_val;

    wdt_guard_decode u_decode (
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .locked   (locked),
        .strobe   (strobe)
    );

    wdt_guard_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_wr (strobe.lock),
        .wdata   (reg_wdata),
        .locked  (locked)
    );

    wdt_guard_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_wr  (strobe.load),
        .ctrl_wr  (strobe.ctrl),
        .load_in  (reg_wdata[CNT_W-1:0]),
        .ctrl_in  (reg_wdata[1:0]),
        .load_val (load_val),
        .en_irq   (en_irq),
        .en_rst   (en_rst)
    );

    wdt_guard_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_irq    (en_irq),
        .en_rst    (en_rst),
        .load_wr   (strobe.load),
        .clear_wr  (strobe.clear),
        .load_in   (reg_wdata[CNT_W-1:0]),
        .load_val  (load_val),
        .count_val (count_val),
        .st_flag   (st_flag),
        .halted    (halted),
        .rst_pulse (wdt_rst_pulse)
    );

    // Interrupt line follows the flag while interrupts are enabled
    always_comb wdt_irq = st_flag && en_irq;

    // Read data mux, zero-extended
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            REG_LOAD:   reg_rdata[CNT_W-1:0] = load_val;
            REG_COUNT:  reg_rdata[CNT_W-1:0] = count_val;
            REG_CTRL:   reg_rdata[1:0]       = {en_rst, en_irq};
            REG_STATUS: reg_rdata[0]         = st_flag;
            REG_LOCK:   reg_rdata[0]         = locked;
            default:    reg_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/wdt_guard_chk.sv
// Cycle-level checks of the watchdog, bound to the top module.
// Assumes it sees the top's internal state through the bind connections.
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              locked,
    input logic              en_irq,
    input logic              en_rst,
    input logic              st_flag,
    input logic              halted,
    input logic [CNT_W-1:0]  count_val,
    input logic [CNT_W-1:0]  load_val,
    input logic              wdt_rst_pulse
);
    // R5
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_pulse |=> !wdt_rst_pulse);

    // R5
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_pulse) |-> ($past(st_flag) && $past(en_rst) && ($past(count_val) == '0)));

    // R4
    flag_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_flag) |-> (($past(count_val) == '0) && $past(en_irq)));

    // R8
    irq_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_irq |=> en_irq);

    // R8
    rst_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_rst |=> en_rst);

    // R10
    locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && reg_we && (reg_addr == REG_LOAD)) |=> $stable(load_val));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_irq && !reg_we) |=> $stable(count_val));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !reg_we) |=> $stable(count_val));

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && reg_we && (reg_addr == REG_CLEAR)) |=> !st_flag);
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .locked        (locked),
    .en_irq        (en_irq),
    .en_rst        (en_rst),
    .st_flag       (st_flag),
    .halted        (halted),
    .count_val     (count_val),
    .load_val      (load_val),
    .wdt_rst_pulse (wdt_rst_pulse)
);

// File: tb/wdt_guard_bench.sv
// Scoreboard bench: scenarios schedule expected interrupt/reset events in a
// queue; a monitor pops and compares them against the observed edges.
module wdt_guard_bench;
    localparam logic [2:0] A_LOAD = 3'd0, A_COUNT = 3'd1, A_CTRL = 3'd2,
                           A_CLEAR = 3'd3, A_STATUS = 3'd4, A_LOCK = 3'd5;

    typedef struct { bit is_rst; int edge_no; } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        wdt_irq;
    logic        wdt_rst_pulse;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b0;
    bit  irq_prev = 1'b0;
    bit  rst_prev = 1'b0;
    ev_t exp_q[$];

    wdt_guard u_wdt_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .wdt_irq       (wdt_irq),
        .wdt_rst_pulse (wdt_rst_pulse)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Driver: call at a falling edge; e is the rising edge that takes the write
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; e = cyc + 1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_edge(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_ev(input bit is_rst, input int e);
        ev_t x;
        x.is_rst = is_rst; x.edge_no = e;
        exp_q.push_back(x);
    endtask

    // Monitor: compares observed interrupt rises and reset pulses to the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (wdt_irq && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R4: unexpected interrupt at edge %0d, expected none", cyc);
                end else begin
                    ev_t x;
                    x = exp_q.pop_front();
                    check("R4 interrupt kind", 32'(x.is_rst), 32'd0);
                    check("R4 interrupt edge", 32'(cyc), 32'(x.edge_no));
                end
            end
            if (wdt_rst_pulse && !rst_prev) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R6: unexpected reset pulse at edge %0d, expected none", cyc);
                end else begin
                    ev_t x;
                    x = exp_q.pop_front();
                    check("R5 reset kind", 32'(x.is_rst), 32'd1);
                    check("R5 reset edge", 32'(cyc), 32'(x.edge_no));
                end
            end
            if (rst_prev)
                check("R5 reset pulse one cycle", 32'(wdt_rst_pulse), 32'd0);
            irq_prev = wdt_irq;
            rst_prev = wdt_rst_pulse;
        end
    end

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int e, c, e2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_LOAD, d);   check("R1 LOAD", d, 32'hFFFF_FFFF);
        rd(A_COUNT, d);  check("R1 COUNT", d, 32'hFFFF_FFFF);
        rd(A_CTRL, d);   check("R1 CTRL", d, 32'd0);
        rd(A_STATUS, d); check("R1 STATUS", d, 32'd0);
        rd(A_LOCK, d);   check("R1 LOCK", d, 32'd0);
        check("R1 irq", 32'(wdt_irq), 32'd0);
        check("R1 rst", 32'(wdt_rst_pulse), 32'd0);
        mon_on = 1'b1;

        // R3 load write reaches the counter; R2 counter holds while disabled
        wr(A_LOAD, 32'd5, e);
        rd(A_COUNT, d); check("R3 COUNT after load", d, 32'd5);
        repeat (6) @(negedge clk);
        rd(A_COUNT, d); check("R2 COUNT holds disabled", d, 32'd5);
        rd(A_CLEAR, d); check("R2 CLEAR reads zero", d, 32'd0);

        // R9 lock with non-key value; R10 writes ignored while locked
        wr(A_LOCK, 32'd0, e);
        rd(A_LOCK, d); check("R9 LOCK after non-key", d, 32'd1);
        wr(A_LOAD, 32'd77, e);
        rd(A_LOAD, d); check("R10 LOAD unchanged", d, 32'd5);
        rd(A_COUNT, d); check("R10 COUNT unchanged", d, 32'd5);
        wr(A_CTRL, 32'd3, e);
        rd(A_CTRL, d); check("R10 CTRL unchanged", d, 32'd0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, d); check("R10 COUNT still idle", d, 32'd5);
        wr(A_LOCK, 32'h1ACC_E551, e);
        rd(A_LOCK, d); check("R9 LOCK after key", d, 32'd0);

        // R4 first expiry; R6 second expiry without reset enable
        wr(A_CTRL, 32'd1, e);
        expect_ev(1'b0, e + 6);
        wait_edge(e + 20);
        rd(A_STATUS, d); check("R6 STATUS stays set", d, 32'd1);
        check("R4 irq high", 32'(wdt_irq), 32'd1);

        // R10 clear and control ignored while locked
        wr(A_LOCK, 32'hDEAD_BEEF, e);
        wr(A_CLEAR, 32'd0, e);
        rd(A_STATUS, d); check("R10 STATUS after locked clear", d, 32'd1);
        check("R10 irq after locked clear", 32'(wdt_irq), 32'd1);
        wr(A_LOCK, 32'h1ACC_E551, e);

        // R8 enables are sticky
        wr(A_CTRL, 32'd0, e);
        rd(A_CTRL, d); check("R8 CTRL sticky", d, 32'd1);

        // R7 clear cancels; R5 escalation to reset and halt
        wr(A_CLEAR, 32'd0, c);
        check("R7 irq dropped", 32'(wdt_irq), 32'd0);
        expect_ev(1'b0, c + 6);
        wr(A_CTRL, 32'd3, e);
        expect_ev(1'b1, c + 12);
        wait_edge(c + 20);
        rd(A_COUNT, d); check("R5 COUNT halted", d, 32'd0);
        repeat (5) @(negedge clk);
        rd(A_COUNT, d); check("R5 COUNT still halted", d, 32'd0);
        check("R5 rst low while halted", 32'(wdt_rst_pulse), 32'd0);

        // R3 load write re-arms with the flag still set
        wr(A_LOAD, 32'd3, e);
        rd(A_COUNT, d); check("R3 COUNT after reload", d, 32'd3);
        expect_ev(1'b1, e + 4);
        wait_edge(e + 10);
        rd(A_COUNT, d); check("R5 COUNT halted again", d, 32'd0);

        // R7 clear before second expiry cancels the reset
        wr(A_CLEAR, 32'd0, c);
        expect_ev(1'b0, c + 4);
        wait_edge(c + 5);
        wr(A_CLEAR, 32'd0, e2);
        check("R7 clear edge", 32'(e2), 32'(c + 6));
        expect_ev(1'b0, e2 + 4);
        expect_ev(1'b1, e2 + 8);
        wait_edge(e2 + 14);

        mon_on = 1'b0;
        while (exp_q.size() > 0) begin
            ev_t x;
            x = exp_q.pop_front();
            n_chk++; n_bad++;
            $display("FAIL R5: missing event kind %0d actual none expected edge %0d", x.is_rst, x.edge_no);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule